// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block moves bytes over a three-wire synchronous serial link: a serial clock, a data output and a data input. Transmit and receive work at the same time and share the serial clock. The clock has two sources. It can come from an internal divider, in which case the block drives it out. It can also arrive on an external clock pin, in which case the block only listens to it. A mode input chooses the source, and it is changed only while the link is quiet.

Each direction has one buffer byte in front of its shift register. Software writes the next byte into the transmit buffer while the current byte is still shifting. When a received byte is complete it moves into a receive buffer, where software reads it later. A byte that is waiting in the transmit buffer when the current byte ends starts at once. The clock then keeps running with no idle gap, so a stream of bytes goes out back to back.

The serial clock idles high. Output data changes on falling edges and input data is sampled on rising edges. Every character is exactly eight bits, sent least significant bit first. No framing, parity or address bits are added.

Top module: `sync_serial_xcvr`

## Requirements
- R1: A character is eight data bits sent least significant bit first. Between falling edge k and falling edge k+1 of the serial clock (k = 1..8), `sdo` carries bit k-1 of the written byte. No other bits are sent.
- R2: With the internal clock selected, `sdo` changes only in the system clock cycle in which `sck_o` falls.
- R3: The receiver samples `sdi` on each rising serial clock edge. The first bit it samples becomes bit 0 of the received byte, and the eighth becomes bit 7.
- R4: After the eighth bit has been sent, `sdo` keeps the value of bit 7 until the next character starts.
- R5: With the internal clock selected (`ext_clk_sel`=0), `sck_oe` is 1. `sck_o` gives exactly eight low pulses per character and stays high when no transfer is running. Each half period lasts `div_val`+1 system clocks, so a full period is 2*(`div_val`+1).
- R6: With the external clock selected (`ext_clk_sel`=1), `sck_oe` is 0 and `sck_o` stays high. Falling and rising edges on `sck_i` shift data out and in. `sck_i` must be much slower than the system clock.
- R7: Transmit and receive work at the same time. During one character, the byte written for transmission goes out on `sdo` while a different byte is collected from `sdi`.
- R8: If the transmit buffer holds a byte when the eighth rising edge of a character arrives, the next character follows at once. The falling-edge spacing stays exactly 2*(`div_val`+1) system clocks across the character boundary, with no stretched high time.
- R9: `tx_empty` is 1 after reset. A `tx_wr` pulse clears it. It is set again when the buffered byte moves into the transmit shift register on a falling edge. A `tx_wr` while `tx_empty` is 0 is ignored.
- R10: `rx_full` goes to 1 when the eighth bit of a character has been sampled, and `rx_byte` then holds that byte. An `rx_rd` pulse clears `rx_full`.
- R11: If a character completes while `rx_full` is still 1, `rx_overrun` goes to 1 and `rx_byte` keeps the older byte. An `rx_rd` pulse clears `rx_overrun`.
- R12: After reset, `sck_o`=1, `sdo`=1, `tx_empty`=1, `rx_full`=0 and `rx_overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_sel | input | 1 | 1: serial clock taken from `sck_i`; 0: internal divider |
| div_val | input | DIV_W | Divider setting N; half period is N+1 system clocks |
| tx_wr | input | 1 | Writes `tx_byte` into the transmit buffer |
| tx_byte | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_rd | input | 1 | Acknowledges the received byte |
| rx_byte | output | 8 | Last received byte |
| rx_full | output | 1 | Received byte waiting |
| rx_overrun | output | 1 | A byte completed while `rx_full` was set |
| sck_o | output | 1 | Serial clock driven in internal mode |
| sck_oe | output | 1 | Output enable for the serial clock pin |
| sck_i | input | 1 | External serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bench keeps the defaults DIV_W=8 and SYNC_STAGES=2. In internal mode it loops `sdo` back to `sdi` and runs with divider values 3 and 5. This gives periods of 8 and 12 system clocks, so the bench can check both the period arithmetic and the spacing across a back-to-back boundary. These settings also leave more than two cycles between a launch and its sample, which the input synchronizer needs. In external mode the bench drives a serial clock with a 20-cycle period and its own input data, so it can see the synchronizer delay and check sending and receiving in the same character.

// File: rtl/sxv_pkg.sv
package sxv_pkg;
  localparam int unsigned CHAR_BITS = 8;
  localparam int unsigned BIT_IDX_W = $clog2(CHAR_BITS);
  localparam int unsigned CNT_W     = BIT_IDX_W + 1;

  // next receive shift value: new bit enters at the top, so the first
  // sampled bit ends up in bit 0 after a full character
  function automatic logic [CHAR_BITS-1:0] shift_in_lsb_first(
    input logic [CHAR_BITS-1:0] cur, input logic bit_in);
    return {bit_in, cur[CHAR_BITS-1:1]};
  endfunction

  // system clocks per serial half period for a divider setting
  function automatic int unsigned half_period_cycles(input int unsigned div);
    return div + 1;
  endfunction
endpackage

// File: rtl/sxv_sync.sv
module sxv_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sxv_clkgen.sv
module sxv_clkgen
  import sxv_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             tx_pending,
  input  logic             sck_ext_sync,
  output logic             fall_ev,
  output logic             rise_ev,
  output logic             sck_o
);
  localparam logic [BIT_IDX_W-1:0] LAST_RISE = BIT_IDX_W'(CHAR_BITS - 1);

  logic [DIV_W-1:0]     div_cnt;
  logic [BIT_IDX_W-1:0] rise_cnt;
  logic                 active;
  logic                 sck_q;
  logic                 ext_prev;

  wire half_done = active && (div_cnt == div_val);
  wire int_fall  = half_done && sck_q;
  wire int_rise  = half_done && !sck_q;
  wire ext_fall  = ext_prev && !sck_ext_sync;
  wire ext_rise  = !ext_prev && sck_ext_sync;

  assign fall_ev = ext_sel ? ext_fall : int_fall;
  assign rise_ev = ext_sel ? ext_rise : int_rise;
  assign sck_o   = sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev <= 1'b1;
    else        ext_prev <= sck_ext_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sck_q    <= 1'b1;
      div_cnt  <= '0;
      rise_cnt <= '0;
    end else if (ext_sel) begin
      active   <= 1'b0;
      sck_q    <= 1'b1;
      div_cnt  <= '0;
      rise_cnt <= '0;
    end else if (!active) begin
      sck_q    <= 1'b1;
      div_cnt  <= '0;
      rise_cnt <= '0;
      if (tx_pending) active <= 1'b1;
    end else if (half_done) begin
      div_cnt <= '0;
      sck_q   <= !sck_q;
      if (!sck_q) begin
        if (rise_cnt == LAST_RISE) begin
          rise_cnt <= '0;
          if (!tx_pending) active <= 1'b0;   // R8: continue only with a byte ready
        end else begin
          rise_cnt <= rise_cnt + 1'b1;
        end
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> sck_q);
  a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_sel && active && !half_done) |=> $stable(sck_q));
  a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_ev && rise_ev));
endmodule

// File: rtl/sxv_tx.sv
module sxv_tx
  import sxv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr,
  input  logic [CHAR_BITS-1:0] wdata,
  input  logic                 fall_ev,
  output logic                 buf_full,
  output logic                 sdo
);
  localparam logic [CNT_W-1:0] ALL_SENT = CNT_W'(CHAR_BITS);

  logic [CHAR_BITS-1:0] buf_q;
  logic [CHAR_BITS-1:0] sh_q;
  logic [CNT_W-1:0]     sent;

  wire shifter_free = (sent == '0) || (sent == ALL_SENT);
  wire load_ev      = fall_ev && shifter_free && buf_full;
  wire shift_ev     = fall_ev && !shifter_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      sent <= '0;
      sdo  <= 1'b1;
    end else if (load_ev) begin
      sh_q <= buf_q;
      sdo  <= buf_q[0];
      sent <= CNT_W'(1);
    end else if (shift_ev) begin
      sdo  <= sh_q[sent[BIT_IDX_W-1:0]];
      sent <= sent + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q    <= '0;
      buf_full <= 1'b0;
    end else if (load_ev) begin
      buf_full <= 1'b0;
    end else if (wr && !buf_full) begin
      buf_q    <= wdata;
      buf_full <= 1'b1;
    end
  end

  a_r2_launch_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(sdo));
  a_r4_msb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sent == ALL_SENT) |-> (sdo == sh_q[CHAR_BITS-1]));
  a_r9_empty_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !buf_full);
  a_r9_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && buf_full && !load_ev) |=> $stable(buf_q));
endmodule

// File: rtl/sxv_rx.sv
module sxv_rx
  import sxv_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rise_ev,
  input  logic                 sdi,
  input  logic                 rd,
  output logic [CHAR_BITS-1:0] rdata,
  output logic                 full,
  output logic                 overrun
);
  localparam logic [BIT_IDX_W-1:0] LAST_BIT = BIT_IDX_W'(CHAR_BITS - 1);

  logic [CHAR_BITS-1:0] sh_q;
  logic [BIT_IDX_W-1:0] got;

  wire [CHAR_BITS-1:0] next_sh = shift_in_lsb_first(sh_q, sdi);
  wire                 done_ev = rise_ev && (got == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      got  <= '0;
    end else if (rise_ev) begin
      sh_q <= next_sh;
      got  <= got + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata   <= '0;
      full    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (done_ev && (!full || rd)) begin
        rdata <= next_sh;
        full  <= 1'b1;
      end else if (rd) begin
        full <= 1'b0;
      end
      if (done_ev && full && !rd) overrun <= 1'b1;
      else if (rd)                overrun <= 1'b0;
    end
  end

  a_r10_full_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && !full) |=> full);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done_ev) |=> (!full && !overrun));
  a_r11_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
    (done_ev && full && !rd) |=> (overrun && $stable(rdata)));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import sxv_pkg::*;
#(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_clk_sel,
  input  logic [DIV_W-1:0]     div_val,
  input  logic                 tx_wr,
  input  logic [CHAR_BITS-1:0] tx_byte,
  output logic                 tx_empty,
  input  logic                 rx_rd,
  output logic [CHAR_BITS-1:0] rx_byte,
  output logic                 rx_full,
  output logic                 rx_overrun,
  output logic                 sck_o,
  output logic                 sck_oe,
  input  logic                 sck_i,
  output logic                 sdo,
  input  logic                 sdi
);
  logic sck_sync, sdi_sync;
  logic fall_ev, rise_ev;
  logic tx_buf_full;

  // same latency on clock and data inputs keeps them aligned
  sxv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sck_i), .q(sck_sync));
  sxv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_sync));

  sxv_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .ext_sel(ext_clk_sel), .div_val(div_val),
    .tx_pending(tx_buf_full), .sck_ext_sync(sck_sync),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .sck_o(sck_o));

  sxv_tx u_tx (
    .clk(clk), .rst_n(rst_n), .wr(tx_wr), .wdata(tx_byte),
    .fall_ev(fall_ev), .buf_full(tx_buf_full), .sdo(sdo));

  sxv_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .sdi(sdi_sync), .rd(rx_rd),
    .rdata(rx_byte), .full(rx_full), .overrun(rx_overrun));

  assign tx_empty = !tx_buf_full;
  assign sck_oe   = !ext_clk_sel;

  a_r6_pin_direction: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk_sel |-> !sck_oe);
  a_r6_ext_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_clk_sel && $past(ext_clk_sel)) |-> sck_o);
endmodule

// File: tb/sync_serial_xcvr_tb_top.sv
module sync_serial_xcvr_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_sel = 1'b0;
  logic [7:0] div_val = 8'd3;
  logic       tx_wr = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_empty;
  logic       rx_rd = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_full, rx_overrun;
  logic       sck_o, sck_oe;
  logic       tb_sck = 1'b1;
  logic       sdo;
  logic       tb_sdi = 1'b1;
  logic       loop_en = 1'b1;
  wire        sdi = loop_en ? sdo : tb_sdi;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;   // 250 MHz

  sync_serial_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk_sel(ext_clk_sel), .div_val(div_val),
    .tx_wr(tx_wr), .tx_byte(tx_byte), .tx_empty(tx_empty),
    .rx_rd(rx_rd), .rx_byte(rx_byte), .rx_full(rx_full), .rx_overrun(rx_overrun),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(tb_sck), .sdo(sdo), .sdi(sdi));

  // serial line monitor, sampled away from the active edge
  int          cyc = 0;
  int          falls = 0;
  int          last_fall = -1;
  int          min_iv = 1000000;
  int          max_iv = 0;
  int          r2_viol = 0;
  logic [15:0] cap = '0;
  logic        mon_sck = 1'b1;
  logic        mon_sdo = 1'b1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (mon_sck && !sck_o) begin
        falls = falls + 1;
        if (last_fall >= 0) begin
          if (cyc - last_fall < min_iv) min_iv = cyc - last_fall;
          if (cyc - last_fall > max_iv) max_iv = cyc - last_fall;
        end
        last_fall = cyc;
      end
      if (!mon_sck && sck_o) cap = {sdo, cap[15:1]};
      if (!ext_clk_sel && (sdo !== mon_sdo) && !(mon_sck && !sck_o))
        r2_viol = r2_viol + 1;
    end
    mon_sck = sck_o;
    mon_sdo = sdo;
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    falls = 0; last_fall = -1; min_iv = 1000000; max_iv = 0; cap = '0; r2_viol = 0;
  endtask

  task automatic write_tx(input logic [7:0] b);
    @(negedge clk); tx_byte = b; tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic read_rx();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_rx_full();
    int n = 0;
    while (!rx_full && n < 4000) begin @(negedge clk); n++; end
    if (!rx_full) chk(1'b0, "R10 rx_full timeout", 0, 1);
  endtask

  task automatic t_reset();
    chk(sck_o == 1'b1,      "R12 sck_o after reset", sck_o, 1);
    chk(sdo == 1'b1,        "R12 sdo after reset", sdo, 1);
    chk(tx_empty == 1'b1,   "R12 tx_empty after reset", tx_empty, 1);
    chk(rx_full == 1'b0,    "R12 rx_full after reset", rx_full, 0);
    chk(rx_overrun == 1'b0, "R12 rx_overrun after reset", rx_overrun, 0);
    chk(sck_oe == 1'b1,     "R5 sck_oe internal mode", sck_oe, 1);
  endtask

  task automatic t_single(input logic [7:0] b, input logic [7:0] dv);
    int per;
    per = 2 * (int'(dv) + 1);
    div_val = dv;
    clr_mon();
    write_tx(b);
    wait_rx_full();
    repeat (3 * per) @(negedge clk);
    chk(falls == 8,              "R5 pulses per char", falls, 8);
    chk(min_iv == per,           "R5 min period", min_iv, per);
    chk(max_iv == per,           "R5 max period", max_iv, per);
    chk(sck_o == 1'b1,           "R5 clock idles high", sck_o, 1);
    chk(cap[15:8] == b,          "R1 lsb-first line bits", cap[15:8], b);
    chk(rx_byte == b,            "R3 received byte", rx_byte, b);
    chk(sdo == b[7],             "R4 msb held on line", sdo, b[7]);
    chk(tx_empty == 1'b1,        "R9 tx_empty after load", tx_empty, 1);
    chk(r2_viol == 0,            "R2 sdo changed off a falling edge", r2_viol, 0);
    read_rx();
    chk(rx_full == 1'b0,         "R10 read clears rx_full", rx_full, 0);
  endtask

  task automatic t_continuous(input logic [7:0] a, input logic [7:0] b);
    int n = 0;
    int per;
    per = 2 * (int'(div_val) + 1);
    clr_mon();
    write_tx(a);
    while (!tx_empty && n < 1000) begin @(negedge clk); n++; end
    chk(tx_empty == 1'b1, "R9 buffer freed at first fall", tx_empty, 1);
    write_tx(b);
    chk(tx_empty == 1'b0, "R9 write clears tx_empty", tx_empty, 0);
    wait_rx_full();
    chk(rx_byte == a, "R8 first of back-to-back", rx_byte, a);
    read_rx();
    wait_rx_full();
    chk(rx_byte == b, "R8 second of back-to-back", rx_byte, b);
    read_rx();
    repeat (3 * per) @(negedge clk);
    chk(falls == 16,      "R8 pulses for two chars", falls, 16);
    chk(min_iv == per,    "R8 no gap min period", min_iv, per);
    chk(max_iv == per,    "R8 no gap max period", max_iv, per);
    chk(cap == {b, a},    "R1 two chars on line", cap, {b, a});
  endtask

  task automatic t_overrun();
    int n = 0;
    write_tx(8'h11);
    wait_rx_full();
    write_tx(8'h22);
    while (!rx_overrun && n < 2000) begin @(negedge clk); n++; end
    chk(rx_overrun == 1'b1, "R11 overrun raised", rx_overrun, 1);
    chk(rx_byte == 8'h11,   "R11 old byte kept", rx_byte, 8'h11);
    chk(rx_full == 1'b1,    "R10 still full on overrun", rx_full, 1);
    repeat (20) @(negedge clk);
    read_rx();
    chk(rx_overrun == 1'b0, "R11 read clears overrun", rx_overrun, 0);
    chk(rx_full == 1'b0,    "R10 read clears full", rx_full, 0);
  endtask

  task automatic t_ignore();
    clr_mon();
    @(negedge clk); tx_byte = 8'h55; tx_wr = 1'b1;
    @(negedge clk); tx_byte = 8'hAA;   // buffer already full: dropped
    @(negedge clk); tx_wr = 1'b0;
    wait_rx_full();
    repeat (40) @(negedge clk);
    chk(falls == 8,       "R9 ignored write sends nothing", falls, 8);
    chk(rx_byte == 8'h55, "R9 first write kept", rx_byte, 8'h55);
    chk(tx_empty == 1'b1, "R9 tx_empty at end", tx_empty, 1);
    read_rx();
  endtask

  task automatic t_external(input logic [7:0] txv, input logic [7:0] rxv);
    logic [7:0] got;
    got = '0;
    loop_en = 1'b0;
    @(negedge clk); ext_clk_sel = 1'b1; tb_sck = 1'b1;
    repeat (5) @(negedge clk);
    chk(sck_oe == 1'b0, "R6 clock pin released", sck_oe, 0);
    write_tx(txv);
    for (int i = 0; i < 8; i++) begin
      tb_sck = 1'b0;
      tb_sdi = rxv[i];
      repeat (10) @(negedge clk);
      got[i] = sdo;
      tb_sck = 1'b1;
      repeat (10) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk(got == txv,       "R7 sent while receiving", got, txv);
    chk(rx_byte == rxv,   "R7 received while sending", rx_byte, rxv);
    chk(rx_full == 1'b1,  "R6 external clock completes char", rx_full, 1);
    chk(sck_o == 1'b1,    "R6 sck_o quiet in external mode", sck_o, 1);
    read_rx();
    @(negedge clk); ext_clk_sel = 1'b0; loop_en = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single(8'hA5, 8'd3);
    t_single(8'h3C, 8'd5);
    div_val = 8'd3;
    t_continuous(8'h81, 8'h7E);
    t_overrun();
    t_ignore();
    t_external(8'h9B, 8'hC6);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule